// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block keeps traffic statistics for one Ethernet MAC. Once per received or transmitted frame, the MAC's receive and transmit paths each raise an end-of-frame strobe together with the frame's byte length and a set of classification flags. The block counts frames and bytes. It also counts frames by type and sorts them into seven length bins. Each direction keeps its own set of counters. On the receive side, a separate counter records frames that exceed the configured maximum size.

Software reads the counters through a simple register read port. Every counter clears when it is read, so each read returns the activity since the previous read. The byte counters are wider than the read port, so each is exposed as a low word and a high word. Reading the low word clears the whole byte counter and captures its upper bits in a snapshot. A later read of the high word returns that snapshot, which keeps the two halves coherent. A global clear input zeroes every counter at once.

Top module: `mac_stat_bank`

## Requirements
- R1: After reset every register in the map reads zero, and the fifo-empty flag follows its input.
- R2: A frame counter increments once per end-of-frame strobe of its direction. It is FRAME_W bits wide, wraps modulo 2^FRAME_W and does not saturate. Slot 2 counts receive frames and slot 21 counts transmit frames.
- R3: A byte counter is OCT_W bits wide and adds the frame length on each end-of-frame strobe, wrapping modulo 2^OCT_W. Its low word reads the lower RD_W bits: slot 0 for receive, slot 19 for transmit.
- R4: A read of the low byte word clears the whole byte counter and latches its bits above RD_W into a snapshot. The high word (slot 1 for receive, slot 20 for transmit) returns that snapshot, zero-extended. Reading the high word does not clear it, and later traffic does not change it.
- R5: Type counters count only frames whose end-of-frame strobe carries the flag. Receive slots 3 to 10 count, in order, multicast, broadcast, CRC error, pause, jabber, short, symbol error and oversize. Transmit slots 22 to 25 count, in order, multicast, broadcast, pause and error.
- R6: Each frame increments exactly one length bin of its direction. The bins cover lengths ≤64, 65–127, 128–255, 256–511, 512–1023, 1024–1518 and ≥1519. Receive bins sit at slots 11 to 17 and transmit bins at slots 26 to 32, in that order.
- R7: A read (rd_en high with rd_addr) returns the selected value on rd_data in the next cycle and clears that counter. An immediate second read of the same slot with no traffic in between returns zero. rd_data holds its value when no read is made.
- R8: An event in the same cycle as a clearing read of its counter is not lost. The read returns the old count, and the counter restarts from the value that event contributes.
- R9: Slot 18 reads the receive maximum-size error count in bits RD_W-2:0. That count increments when rx_eof and rx_len_err are both high, wraps modulo 2^(RD_W-1), and clears when read. Bit RD_W-1 of slot 18 is rx_fifo_empty as sampled in the read cycle and is not part of the count.
- R10: clr_all zeroes every counter and both snapshots in one cycle. Events in that same cycle are counted into the cleared values, and a read in that cycle returns the values from before the clear.
- R11: Addresses 33 and above read zero and clear nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_all | input | 1 | Zero all counters and snapshots |
| rx_eof | input | 1 | Receive end-of-frame strobe |
| rx_len | input | LEN_W | Receive frame length in bytes |
| rx_mcast | input | 1 | Receive frame is multicast |
| rx_bcast | input | 1 | Receive frame is broadcast |
| rx_crc_err | input | 1 | Receive frame has a CRC error |
| rx_pause | input | 1 | Receive frame is a pause frame |
| rx_jabber | input | 1 | Receive frame is a jabber frame |
| rx_short | input | 1 | Receive frame is short |
| rx_sym_err | input | 1 | Receive frame has a symbol code error |
| rx_oversize | input | 1 | Receive frame is oversize |
| rx_len_err | input | 1 | Receive frame exceeded the maximum size limit |
| rx_fifo_empty | input | 1 | Receive FIFO empty status |
| tx_eof | input | 1 | Transmit end-of-frame strobe |
| tx_len | input | LEN_W | Transmit frame length in bytes |
| tx_mcast | input | 1 | Transmit frame is multicast |
| tx_bcast | input | 1 | Transmit frame is broadcast |
| tx_pause | input | 1 | Transmit frame is a pause frame |
| tx_err | input | 1 | Transmit frame errored (bad FCS, underrun) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 6 | Read slot address |
| rd_data | output | RD_W | Read data, valid the cycle after rd_en |

## Verification
The bench builds the block with an 8-bit read word, 8-bit frame counters, a 12-bit byte counter and an 11-bit length. With these values, frame-counter wrap, byte-counter wrap and high-word snapshots all occur within a few hundred frames. The sweep covers every length from 0 to 2047 in both directions, so it crosses every bin boundary. Throughout the sweep the read port cycles through every slot and three unmapped addresses, so clearing reads regularly coincide with traffic. A bench model, computed arithmetically, predicts every read.

// File: rtl/msb_pkg.sv
package msb_pkg;
  localparam int NUM_BINS  = 7;
  localparam int RX_FLAGS  = 8;
  localparam int TX_FLAGS  = 4;
  // Per-direction slot layout
  localparam int SLOT_OCT_LO = 0;
  localparam int SLOT_OCT_HI = 1;
  localparam int SLOT_FRM    = 2;
  localparam int SLOT_FLAG0  = 3;
  localparam int RX_SLOTS    = SLOT_FLAG0 + RX_FLAGS + NUM_BINS;
  localparam int TX_SLOTS    = SLOT_FLAG0 + TX_FLAGS + NUM_BINS;
  localparam int RX_BASE     = 0;
  localparam int MPS_SLOT    = RX_BASE + RX_SLOTS;
  localparam int TX_BASE     = MPS_SLOT + 1;
  localparam int NUM_SLOTS   = TX_BASE + TX_SLOTS;
  localparam int ADDR_W      = $clog2(NUM_SLOTS);
  // Inclusive upper length of bins 0..5; bin 6 takes the rest
  localparam int BIN_TOP [0:NUM_BINS-2] = '{64, 127, 255, 511, 1023, 1518};
endpackage

// File: rtl/msb_counter.sv
module msb_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         add_en,
  input  logic [W-1:0] add_val,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_nxt;
  logic         cnt_en;

  always_comb begin
    cnt_en  = clr | add_en;
    cnt_nxt = (clr ? '0 : cnt_q) + (add_en ? add_val : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign cnt = cnt_q;

  // R7: a clear without traffic leaves zero
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !add_en) |=> (cnt_q == '0));
  // R8: a clear with traffic keeps exactly that traffic
  p_fresh_keeps_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && add_en) |=> (cnt_q == $past(add_val)));
  // R7: no clear, no traffic, no change
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !add_en) |=> $stable(cnt_q));
endmodule

// File: rtl/msb_len_classify.sv
module msb_len_classify
  import msb_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic [LEN_W-1:0]    len,
  output logic [NUM_BINS-1:0] bin_hot
);
  logic [31:0]         len_ext;
  logic [NUM_BINS-2:0] at_most;

  assign len_ext = 32'(len);

  for (genvar i = 0; i < NUM_BINS - 1; i++) begin : g_cmp
    assign at_most[i] = (len_ext <= 32'(BIN_TOP[i]));
  end

  assign bin_hot[0] = at_most[0];
  for (genvar i = 1; i < NUM_BINS - 1; i++) begin : g_bin
    assign bin_hot[i] = at_most[i] & ~at_most[i-1];
  end
  assign bin_hot[NUM_BINS-1] = ~at_most[NUM_BINS-2];
endmodule

// File: rtl/msb_dir_bank.sv
module msb_dir_bank
  import msb_pkg::*;
#(
  parameter int BASE    = 0,
  parameter int NF      = 8,
  parameter int LEN_W   = 14,
  parameter int FRAME_W = 32,
  parameter int OCT_W   = 45,
  parameter int RD_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              eof,
  input  logic [LEN_W-1:0]  len,
  input  logic [NF-1:0]     flags,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              hit,
  output logic [RD_W-1:0]   rd_val
);
  localparam int SLOTS = SLOT_FLAG0 + NF + NUM_BINS;
  localparam int BIN0  = SLOT_FLAG0 + NF;
  localparam int HI_W  = OCT_W - RD_W;

  logic [31:0]         addr_ext, ofs;
  logic [SLOTS-1:0]    sel;
  logic [RD_W-1:0]     slot_val [SLOTS];
  logic [NUM_BINS-1:0] bin_hot;
  logic [OCT_W-1:0]    oct_cnt;
  logic [FRAME_W-1:0]  frm_cnt;
  logic [HI_W-1:0]     shadow_q, shadow_nxt;
  logic                shadow_en;

  // Address decode
  assign addr_ext = 32'(rd_addr);
  assign ofs      = addr_ext - 32'(BASE);
  assign hit      = rd_en && (addr_ext >= 32'(BASE)) && (addr_ext < 32'(BASE + SLOTS));

  for (genvar s = 0; s < SLOTS; s++) begin : g_sel
    assign sel[s] = hit && (ofs == 32'(s));
  end

  // Byte counter and high-word snapshot
  msb_counter #(.W(OCT_W)) u_oct (
    .clk(clk), .rst_n(rst_n),
    .clr(clr_all | sel[SLOT_OCT_LO]),
    .add_en(eof), .add_val(OCT_W'(len)),
    .cnt(oct_cnt)
  );

  always_comb begin
    shadow_en  = clr_all | sel[SLOT_OCT_LO];
    shadow_nxt = clr_all ? '0 : oct_cnt[OCT_W-1:RD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shadow_q <= '0;
    else if (shadow_en) shadow_q <= shadow_nxt;
  end

  assign slot_val[SLOT_OCT_LO] = oct_cnt[RD_W-1:0];
  assign slot_val[SLOT_OCT_HI] = RD_W'(shadow_q);

  // Frame counter
  msb_counter #(.W(FRAME_W)) u_frm (
    .clk(clk), .rst_n(rst_n),
    .clr(clr_all | sel[SLOT_FRM]),
    .add_en(eof), .add_val(FRAME_W'(1)),
    .cnt(frm_cnt)
  );
  assign slot_val[SLOT_FRM] = RD_W'(frm_cnt);

  // Type counters
  for (genvar f = 0; f < NF; f++) begin : g_flag
    logic [FRAME_W-1:0] c;
    msb_counter #(.W(FRAME_W)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .clr(clr_all | sel[SLOT_FLAG0+f]),
      .add_en(eof & flags[f]), .add_val(FRAME_W'(1)),
      .cnt(c)
    );
    assign slot_val[SLOT_FLAG0+f] = RD_W'(c);
  end

  // Length bins
  msb_len_classify #(.LEN_W(LEN_W)) u_cls (
    .len(len), .bin_hot(bin_hot)
  );

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    logic [FRAME_W-1:0] c;
    msb_counter #(.W(FRAME_W)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .clr(clr_all | sel[BIN0+b]),
      .add_en(eof & bin_hot[b]), .add_val(FRAME_W'(1)),
      .cnt(c)
    );
    assign slot_val[BIN0+b] = RD_W'(c);
  end

  // Read select
  always_comb begin
    rd_val = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (sel[s]) rd_val = slot_val[s];
    end
  end

  // R6: each frame lands in exactly one bin
  p_one_bin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> $onehot(bin_hot));
  // R4: snapshot only moves on a low-word read or global clear
  p_snapshot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel[SLOT_OCT_LO] && !clr_all) |=> $stable(shadow_q));
  // R4: reading the high word leaves the byte counter alone
  p_hi_read_no_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[SLOT_OCT_HI] && !eof && !clr_all) |=> $stable(oct_cnt));
endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
  import msb_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int FRAME_W = 32,
  parameter int OCT_W   = 45,
  parameter int RD_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              rx_eof,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic              rx_mcast,
  input  logic              rx_bcast,
  input  logic              rx_crc_err,
  input  logic              rx_pause,
  input  logic              rx_jabber,
  input  logic              rx_short,
  input  logic              rx_sym_err,
  input  logic              rx_oversize,
  input  logic              rx_len_err,
  input  logic              rx_fifo_empty,
  input  logic              tx_eof,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic              tx_mcast,
  input  logic              tx_bcast,
  input  logic              tx_pause,
  input  logic              tx_err,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [RD_W-1:0]   rd_data
);
  localparam int MPS_W = RD_W - 1;

  logic [RX_FLAGS-1:0] rx_flags;
  logic [TX_FLAGS-1:0] tx_flags;
  logic                rx_hit, tx_hit, mps_sel;
  logic [RD_W-1:0]     rx_val, tx_val, rd_nxt, rd_q;
  logic [MPS_W-1:0]    mps_cnt;

  assign rx_flags = {rx_oversize, rx_sym_err, rx_short, rx_jabber,
                     rx_pause, rx_crc_err, rx_bcast, rx_mcast};
  assign tx_flags = {tx_err, tx_pause, tx_bcast, tx_mcast};

  msb_dir_bank #(
    .BASE(RX_BASE), .NF(RX_FLAGS), .LEN_W(LEN_W),
    .FRAME_W(FRAME_W), .OCT_W(OCT_W), .RD_W(RD_W)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
    .eof(rx_eof), .len(rx_len), .flags(rx_flags),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .hit(rx_hit), .rd_val(rx_val)
  );

  msb_dir_bank #(
    .BASE(TX_BASE), .NF(TX_FLAGS), .LEN_W(LEN_W),
    .FRAME_W(FRAME_W), .OCT_W(OCT_W), .RD_W(RD_W)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
    .eof(tx_eof), .len(tx_len), .flags(tx_flags),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .hit(tx_hit), .rd_val(tx_val)
  );

  // Maximum-size error count with fifo-empty status on top
  assign mps_sel = rd_en && (rd_addr == ADDR_W'(MPS_SLOT));

  msb_counter #(.W(MPS_W)) u_mps (
    .clk(clk), .rst_n(rst_n),
    .clr(clr_all | mps_sel),
    .add_en(rx_eof & rx_len_err), .add_val(MPS_W'(1)),
    .cnt(mps_cnt)
  );

  always_comb begin
    if (rx_hit)       rd_nxt = rx_val;
    else if (tx_hit)  rd_nxt = tx_val;
    else if (mps_sel) rd_nxt = {rx_fifo_empty, mps_cnt};
    else              rd_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_nxt;
  end

  assign rd_data = rd_q;

  // R11: unmapped addresses read zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (32'(rd_addr) >= NUM_SLOTS)) |=> (rd_data == '0));
  // R9: status bit reflects the fifo at the read cycle
  p_empty_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_addr == ADDR_W'(MPS_SLOT))) |=> (rd_data[RD_W-1] == $past(rx_fifo_empty)));
  // R7: data holds between reads
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/mac_stat_bank_bench.sv
module mac_stat_bank_bench;
  localparam int LEN_W = 11, FRAME_W = 8, OCT_W = 12, RD_W = 8;
  localparam int NSLOT = 33;

  logic clk = 1'b0, rst_n = 1'b0, clr_all = 1'b0;
  logic rx_eof = 0, rx_mcast = 0, rx_bcast = 0, rx_crc_err = 0, rx_pause = 0;
  logic rx_jabber = 0, rx_short = 0, rx_sym_err = 0, rx_oversize = 0;
  logic rx_len_err = 0, rx_fifo_empty = 0;
  logic tx_eof = 0, tx_mcast = 0, tx_bcast = 0, tx_pause = 0, tx_err = 0;
  logic [LEN_W-1:0] rx_len = '0, tx_len = '0;
  logic rd_en = 0;
  logic [5:0] rd_addr = '0;
  logic [RD_W-1:0] rd_data;

  always #2 clk = ~clk;

  mac_stat_bank #(.LEN_W(LEN_W), .FRAME_W(FRAME_W), .OCT_W(OCT_W), .RD_W(RD_W)) u_mac_stat_bank (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
    .rx_eof(rx_eof), .rx_len(rx_len), .rx_mcast(rx_mcast), .rx_bcast(rx_bcast),
    .rx_crc_err(rx_crc_err), .rx_pause(rx_pause), .rx_jabber(rx_jabber),
    .rx_short(rx_short), .rx_sym_err(rx_sym_err), .rx_oversize(rx_oversize),
    .rx_len_err(rx_len_err), .rx_fifo_empty(rx_fifo_empty),
    .tx_eof(tx_eof), .tx_len(tx_len), .tx_mcast(tx_mcast), .tx_bcast(tx_bcast),
    .tx_pause(tx_pause), .tx_err(tx_err),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  longint mdl [0:NSLOT-1];
  longint shd_rx, shd_tx;
  int checks = 0, fails = 0;
  bit pend = 0;
  longint pend_exp;
  int pend_addr;
  string pend_tag;

  function automatic int bin_of(int len);
    if (len <= 64) return 0;
    if (len <= 127) return 1;
    if (len <= 255) return 2;
    if (len <= 511) return 3;
    if (len <= 1023) return 4;
    if (len <= 1518) return 5;
    return 6;
  endfunction

  function automatic string tag_of(int a);
    if (a == 0 || a == 19) return "R3";
    if (a == 1 || a == 20) return "R4";
    if (a == 2 || a == 21) return "R2";
    if ((a >= 3 && a <= 10) || (a >= 22 && a <= 25)) return "R5";
    if ((a >= 11 && a <= 17) || (a >= 26 && a <= 32)) return "R6";
    if (a == 18) return "R9";
    return "R11";
  endfunction

  task automatic compare();
    if (pend) begin
      checks++;
      if (rd_data !== RD_W'(pend_exp)) begin
        fails++;
        $display("FAIL %s addr %0d: actual %0h expected %0h", pend_tag, pend_addr, rd_data, RD_W'(pend_exp));
      end
      pend = 0;
    end
  endtask

  task automatic step(input bit rxe, input int rxl, input bit [7:0] rxf, input bit rxm,
                      input bit fe, input bit txe, input int txl, input bit [3:0] txf,
                      input bit ca, input bit re, input int ra, input string tag);
    @(negedge clk);
    compare();
    rx_eof = rxe; rx_len = LEN_W'(rxl);
    {rx_oversize, rx_sym_err, rx_short, rx_jabber, rx_pause, rx_crc_err, rx_bcast, rx_mcast} = rxf;
    rx_len_err = rxm; rx_fifo_empty = fe;
    tx_eof = txe; tx_len = LEN_W'(txl);
    {tx_err, tx_pause, tx_bcast, tx_mcast} = txf;
    clr_all = ca; rd_en = re; rd_addr = 6'(ra);
    if (re) begin
      pend = 1; pend_addr = ra;
      pend_tag = (tag == "") ? tag_of(ra) : tag;
      if (ra == 0) begin pend_exp = mdl[0] & 255; shd_rx = (mdl[0] >> 8) & 15; mdl[0] = 0; end
      else if (ra == 19) begin pend_exp = mdl[19] & 255; shd_tx = (mdl[19] >> 8) & 15; mdl[19] = 0; end
      else if (ra == 1) pend_exp = shd_rx;
      else if (ra == 20) pend_exp = shd_tx;
      else if (ra == 18) begin pend_exp = (longint'(fe) << 7) | (mdl[18] & 127); mdl[18] = 0; end
      else if (ra < NSLOT) begin pend_exp = mdl[ra] & 255; mdl[ra] = 0; end
      else pend_exp = 0;
    end
    if (ca) begin
      for (int k = 0; k < NSLOT; k++) mdl[k] = 0;
      shd_rx = 0; shd_tx = 0;
    end
    if (rxe) begin
      mdl[0] += rxl; mdl[2]++;
      for (int f = 0; f < 8; f++) if (rxf[f]) mdl[3+f]++;
      mdl[11 + bin_of(rxl)]++;
      if (rxm) mdl[18]++;
    end
    if (txe) begin
      mdl[19] += txl; mdl[21]++;
      for (int f = 0; f < 4; f++) if (txf[f]) mdl[22+f]++;
      mdl[26 + bin_of(txl)]++;
    end
  endtask

  task automatic rd(input int ra, input bit fe, input string tag);
    step(0, 0, 0, 0, fe, 0, 0, 0, 0, 1, ra, tag);
  endtask

  task automatic rx_frame(input int len, input bit rxm, input bit fe);
    step(1, len, 8'h00, rxm, fe, 0, 0, 0, 0, 0, 0, "");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < NSLOT; k++) mdl[k] = 0;
    shd_rx = 0; shd_tx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of every slot
    for (int a = 0; a < 36; a++) rd(a, 0, "R1");

    // Sweep all lengths, traffic in both directions, reads on every slot
    for (int i = 0; i < 4096; i++) begin
      int rl;
      rl = i % 2048;
      step((i % 7) != 6, rl, 8'((i * 37) ^ (i >> 3)), (i % 5) == 0, 1'((i >> 2) & 1),
           (i % 3) != 0, 2047 - rl, 4'((i * 11) >> 2), i == 1500, 1'b1, i % 36, "");
    end
    for (int a = 0; a < 36; a++) rd(a, 0, "");

    // R4: high-word snapshot coherence
    for (int k = 0; k < 3; k++) rx_frame(700, 0, 0);
    rd(0, 0, "R4");
    rx_frame(1000, 0, 0); rx_frame(1000, 0, 0);
    rd(1, 0, "R4");
    rd(1, 0, "R4");
    rd(0, 0, "R4");
    rd(1, 0, "R4");

    // R8: event coinciding with a clearing read
    rx_frame(100, 0, 0); rx_frame(100, 0, 0);
    step(1, 100, 8'h01, 0, 0, 0, 0, 0, 0, 1, 2, "R8");
    rd(2, 0, "R8");
    step(1, 90, 8'h01, 0, 0, 0, 0, 0, 0, 1, 3, "R8");
    rd(3, 0, "R8");

    // R7: back-to-back reads
    rx_frame(64, 0, 0);
    rd(2, 0, "R7");
    rd(2, 0, "R7");

    // R2 / R6: frame counter wrap
    for (int k = 0; k < 260; k++) rx_frame(64, 0, 0);
    rd(2, 0, "R2");
    rd(11, 0, "R6");
    rd(0, 0, "R3");
    rd(1, 0, "R4");

    // R9: error count with status flag
    for (int k = 0; k < 130; k++) rx_frame(2000, 1, 1);
    rd(18, 1, "R9");
    rx_frame(2000, 1, 0);
    rd(18, 0, "R9");
    rd(18, 1, "R9");
    rd(17, 0, "R6");

    // R10: global clear with coincident traffic and read
    for (int k = 0; k < 5; k++) step(1, 300, 8'hff, 1, 0, 1, 1600, 4'hf, 0, 0, 0, "");
    step(1, 70, 8'h00, 0, 0, 1, 65, 4'h2, 1, 1, 2, "R10");
    for (int a = 0; a < NSLOT; a++) rd(a, 0, "R10");

    // R11: unmapped reads neither return data nor clear
    for (int k = 0; k < 5; k++) step(1, 200, 8'h04, 0, 0, 1, 128, 4'h8, 0, 0, 0, "");
    for (int a = 33; a < 64; a++) rd(a, 0, "R11");
    rd(2, 0, "R11");
    rd(25, 0, "R11");
    rd(21, 0, "R11");

    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    @(negedge clk);
    compare();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule